// File: doc/BRIEF.md
# USB Host Controller Register File

This block holds the software-visible register set of a USB 1.1 host controller behind a narrow I/O bus with byte, word and long accesses. It keeps the command word, the status flags, the interrupt enables, an 11-bit frame counter value, the frame-list base pointer, the start-of-frame timing byte, and one status/control register for each root-hub port. A level interrupt is formed from the status flags and their enables.

The schedule engine and the port hardware sit next to this block and report to it through one-cycle event pulses: frame completion, short-packet detection, transfer error, host system error, process error, resume signalling, and device attach or detach with the device speed. In the other direction the block drives the run level, a one-cycle reset request for each port, and a one-cycle global bus reset request.

A status bit for "USB interrupt" has two possible sources. A private two-bit source register records which of them set it, so that each source can be masked separately at the interrupt output. Writing a one to the shared status bit clears both sources.

Top module: `usbhc_regfile`

## Requirements
- R1: A word write to offset 0x00 with bit 1 (controller reset) or bit 2 (global reset) set returns every register to its reset value (command 0, status 0, enables 0, frame 0, base 0, timing byte 64) and stores nothing of the written value. Bit 2 also raises `glob_rst_pulse` for exactly the next cycle. Any other command write stores the 16-bit value, and `run` follows command bit 0.
- R2: A word write to offset 0x02 clears each status bit (bit 0 interrupt, 1 transfer error, 2 resume detect, 3 host system error, 4 process error, 5 halted) where the written value has a one. A one in bit 0 also clears both interrupt sources.
- R3: A command write that changes bit 0 from 0 to 1 clears status bit 5 (halted). A command write with bit 0 at 0 sets halted. A command write with bit 0 at 1 while run is already set leaves halted unchanged.
- R4: `irq` is high when any of these holds: source 0 (frame done) with enable bit 2; source 1 (short packet) with enable bit 3; transfer error with enable bit 0; resume detect with enable bit 1; host system error; process error. The last two need no enable.
- R5: The frame number (offset 0x06, word) is 11 bits wide and accepts writes only while halted is set. The frame-list base (offset 0x08, long) always reads with its low 12 bits at zero. The timing byte (offset 0x0C, byte) resets to 64.
- R6: A word write to a port register (offset 0x10 + 2*n) keeps the old value of bits 0, 1, 3..8 and takes the written value into bits 2 and 9..15. After that, bit 1 (connect change) and bit 3 (enable change) are cleared where the written value has a one. Each port register resets to 0x0080.
- R7: A port write that takes bit 9 from 0 to 1 raises that port's bit of `port_rst_pulse` for exactly the next cycle.
- R8: Attach sets bit 0 (connected) and bit 1 (connect change), and loads bit 8 from `dev_lowspeed`. Detach clears a set bit 0 and sets bit 1, and clears a set bit 2 (enabled) and sets bit 3. Attach takes priority over detach in the same cycle.
- R9: An attach, a detach or `ev_resume` while command bit 3 (suspend enable) is set sets command bit 4 (force resume) and status bit 2 (resume detect).
- R10: `bus_size` encodes 0 byte, 1 word, 2 long, 3 none. Writes whose size does not match the register are ignored. A word read of an unimplemented port or an unmapped offset returns 0xff7f, a byte read other than 0x0C returns 0xff, a long read other than 0x08 returns 0xffffffff, and size 3 reads 0.
- R11: After a controller or global reset, a port that was connected reads 0x0083 with its old bit 8 kept. A port that was not connected reads 0x0080.
- R12: Events are applied after a bus write in the same cycle, so an event flag is set even when a clearing write to the same register arrives in that cycle. All updates show on the clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_size | input | 2 | access size: 0 byte, 1 word, 2 long, 3 none |
| bus_addr | input | 5 | register offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data (combinational) |
| ev_frame_done | input | 1 | frame completion with interrupt request |
| ev_short_pkt | input | 1 | short packet detected |
| ev_xfer_err | input | 1 | transfer error |
| ev_host_err | input | 1 | host system error |
| ev_proc_err | input | 1 | process error |
| ev_resume | input | 1 | resume signalling seen |
| dev_attach | input | NPORTS | device attached, per port |
| dev_detach | input | NPORTS | device detached, per port |
| dev_lowspeed | input | NPORTS | speed of the attaching device |
| irq | output | 1 | level interrupt |
| run | output | 1 | run/stop level |
| port_rst_pulse | output | NPORTS | per-port reset request pulse |
| glob_rst_pulse | output | 1 | global bus reset pulse |

## Verification
The bench builds the block with the default of two ports. Offset 0x14 therefore falls just past the last implemented port, which puts the absent-port read value and the dropped write within reach. With two ports, random attach, detach and enable traffic also hits every connect-change and enable-change corner on both registers, including attach and detach in the same cycle. Controller resets issued with ports connected or empty exercise both outcomes of the port-preserving reset.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    localparam logic [4:0] A_CMD = 5'h00;
    localparam logic [4:0] A_STS = 5'h02;
    localparam logic [4:0] A_IEN = 5'h04;
    localparam logic [4:0] A_FRN = 5'h06;
    localparam logic [4:0] A_FLB = 5'h08;
    localparam logic [4:0] A_SOF = 5'h0c;

    localparam int FRN_W   = 11;
    localparam int STS_W   = 6;
    localparam int FLB_LSB = 12;

    // command bits
    localparam int CB_RUN  = 0;
    localparam int CB_HCRS = 1;
    localparam int CB_GRST = 2;
    localparam int CB_SUSP = 3;
    localparam int CB_FRES = 4;
    // status bits
    localparam int SB_INT  = 0;
    localparam int SB_ERR  = 1;
    localparam int SB_RES  = 2;
    localparam int SB_HSE  = 3;
    localparam int SB_PERR = 4;
    localparam int SB_HALT = 5;
    // port bits
    localparam int PB_CONN = 0;
    localparam int PB_CCHG = 1;
    localparam int PB_EN   = 2;
    localparam int PB_ECHG = 3;
    localparam int PB_LS   = 8;
    localparam int PB_RST  = 9;

    localparam logic [15:0] PORT_KEEP   = 16'h01fb;
    localparam logic [15:0] PORT_W1C    = 16'h000a;
    localparam logic [15:0] PORT_INIT   = 16'h0080;
    localparam logic [15:0] PORT_ABSENT = 16'hff7f;
    localparam logic [7:0]  SOF_INIT    = 8'd64;

    typedef struct packed {
        logic              wr;
        acc_size_e         size;
        logic [4:0]        addr;
        logic [31:0]       data;
    } bus_req_t;

    typedef struct packed {
        logic [15:0]       cmd;
        logic [STS_W-1:0]  sts;
        logic [1:0]        src;
        logic [15:0]       ien;
        logic [FRN_W-1:0]  frn;
        logic [31:0]       flb;
        logic [7:0]        sof;
    } core_regs_t;

    function automatic core_regs_t core_init();
        core_regs_t v;
        v     = '0;
        v.sof = SOF_INIT;
        return v;
    endfunction

    function automatic logic [15:0] port_bus_write(logic [15:0] old, logic [15:0] w);
        logic [15:0] v;
        v = (old & PORT_KEEP) | (w & ~PORT_KEEP);
        return v & ~(w & PORT_W1C);
    endfunction

    function automatic logic [15:0] port_on_attach(logic [15:0] old, logic ls);
        logic [15:0] v;
        v          = old;
        v[PB_CONN] = 1'b1;
        v[PB_CCHG] = 1'b1;
        v[PB_LS]   = ls;
        return v;
    endfunction

    function automatic logic [15:0] port_on_detach(logic [15:0] old);
        logic [15:0] v;
        v = old;
        if (v[PB_CONN]) begin
            v[PB_CONN] = 1'b0;
            v[PB_CCHG] = 1'b1;
        end
        if (v[PB_EN]) begin
            v[PB_EN]   = 1'b0;
            v[PB_ECHG] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [15:0] port_on_reset(logic [15:0] old);
        logic [15:0] v;
        v = PORT_INIT;
        if (old[PB_CONN]) begin
            v[PB_CONN] = 1'b1;
            v[PB_CCHG] = 1'b1;
            v[PB_LS]   = old[PB_LS];
        end
        return v;
    endfunction

endpackage

// File: rtl/usbhc_core.sv
module usbhc_core
    import usbhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req,
    input  logic       ev_frame_done,
    input  logic       ev_short_pkt,
    input  logic       ev_xfer_err,
    input  logic       ev_host_err,
    input  logic       ev_proc_err,
    input  logic       conn_evt,
    output core_regs_t regs,
    output logic       ctl_reset,
    output logic       glob_pulse
);

    core_regs_t r, nxt;
    logic       word_wr, cmd_wr;

    assign word_wr   = req.wr && (req.size == SZ_WORD);
    assign cmd_wr    = word_wr && (req.addr == A_CMD);
    assign ctl_reset = cmd_wr && (req.data[CB_HCRS] || req.data[CB_GRST]);

    always_comb begin
        nxt = r;
        if (ctl_reset) begin
            nxt = core_init();
        end else if (word_wr) begin
            case (req.addr)
                A_CMD: begin
                    if (req.data[CB_RUN] && !r.cmd[CB_RUN])
                        nxt.sts[SB_HALT] = 1'b0;
                    else if (!req.data[CB_RUN])
                        nxt.sts[SB_HALT] = 1'b1;
                    nxt.cmd = req.data[15:0];
                end
                A_STS: begin
                    nxt.sts = r.sts & ~req.data[STS_W-1:0];
                    if (req.data[SB_INT])
                        nxt.src = '0;
                end
                A_IEN: nxt.ien = req.data[15:0];
                A_FRN: if (r.sts[SB_HALT]) nxt.frn = req.data[FRN_W-1:0];
                default: ;
            endcase
        end else if (req.wr && req.size == SZ_LONG && req.addr == A_FLB) begin
            nxt.flb = {req.data[31:FLB_LSB], {FLB_LSB{1'b0}}};
        end else if (req.wr && req.size == SZ_BYTE && req.addr == A_SOF) begin
            nxt.sof = req.data[7:0];
        end

        // events land after the bus write
        if (ev_frame_done) begin
            nxt.src[0]      = 1'b1;
            nxt.sts[SB_INT] = 1'b1;
        end
        if (ev_short_pkt) begin
            nxt.src[1]      = 1'b1;
            nxt.sts[SB_INT] = 1'b1;
        end
        if (ev_xfer_err) nxt.sts[SB_ERR]  = 1'b1;
        if (ev_host_err) nxt.sts[SB_HSE]  = 1'b1;
        if (ev_proc_err) nxt.sts[SB_PERR] = 1'b1;
        if (conn_evt && nxt.cmd[CB_SUSP]) begin
            nxt.cmd[CB_FRES] = 1'b1;
            nxt.sts[SB_RES]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r          <= core_init();
            glob_pulse <= 1'b0;
        end else begin
            r          <= nxt;
            glob_pulse <= cmd_wr && req.data[CB_GRST];
        end
    end

    assign regs = r;

    AST_HALT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !ctl_reset && !req.data[CB_RUN]) |=> r.sts[SB_HALT]); // R3

    AST_FRN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (word_wr && req.addr == A_FRN && !r.sts[SB_HALT]) |=> $stable(r.frn)); // R5

    AST_SOF_RESTORED: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |=> (r.sof == SOF_INIT)); // R1

endmodule

// File: rtl/usbhc_port.sv
module usbhc_port
    import usbhc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_reset,
    input  logic        wr_sel,
    input  logic [15:0] wdata,
    input  logic        attach,
    input  logic        detach,
    input  logic        lowspeed,
    output logic [15:0] ctrl,
    output logic        rst_pulse
);

    logic [15:0] nxt;
    logic        pulse_d;

    always_comb begin
        nxt = ctrl;
        if (ctl_reset)
            nxt = port_on_reset(ctrl);
        else if (wr_sel)
            nxt = port_bus_write(ctrl, wdata);
        if (attach)
            nxt = port_on_attach(nxt, lowspeed);
        else if (detach)
            nxt = port_on_detach(nxt);
    end

    assign pulse_d = wr_sel && wdata[PB_RST] && !ctrl[PB_RST];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= PORT_INIT;
            rst_pulse <= 1'b0;
        end else begin
            ctrl      <= nxt;
            rst_pulse <= pulse_d;
        end
    end

    AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse); // R7

    AST_CHG_ACK: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata[PB_CCHG] && !attach && !detach) |=> !ctrl[PB_CCHG]); // R6

endmodule

// File: rtl/usbhc_irq.sv
module usbhc_irq
    import usbhc_pkg::*;
(
    input  logic [STS_W-1:0] sts,
    input  logic [1:0]       src,
    input  logic [15:0]      ien,
    output logic             irq
);

    logic [15:0] unused_ien;
    assign unused_ien = {ien[15:4], 4'b0};

    always_comb begin
        irq = (src[0] && ien[2]) ||
              (src[1] && ien[3]) ||
              (sts[SB_ERR] && ien[0]) ||
              (sts[SB_RES] && ien[1]) ||
              sts[SB_HSE] || sts[SB_PERR];
    end

endmodule

// File: rtl/usbhc_regfile.sv
module usbhc_regfile
    import usbhc_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_frame_done,
    input  logic              ev_short_pkt,
    input  logic              ev_xfer_err,
    input  logic              ev_host_err,
    input  logic              ev_proc_err,
    input  logic              ev_resume,
    input  logic [NPORTS-1:0] dev_attach,
    input  logic [NPORTS-1:0] dev_detach,
    input  logic [NPORTS-1:0] dev_lowspeed,
    output logic              irq,
    output logic              run,
    output logic [NPORTS-1:0] port_rst_pulse,
    output logic              glob_rst_pulse
);

    localparam int IDX_W = 3;

    bus_req_t    req;
    core_regs_t  regs;
    logic        ctl_reset;
    logic        conn_evt;
    logic        port_space;
    logic [15:0] port_ctrl [NPORTS];

    assign req.wr   = bus_wr;
    assign req.size = acc_size_e'(bus_size);
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    assign conn_evt   = (|dev_attach) || (|dev_detach) || ev_resume;
    assign port_space = bus_addr[4];

    usbhc_core u_core (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .ev_frame_done (ev_frame_done),
        .ev_short_pkt  (ev_short_pkt),
        .ev_xfer_err   (ev_xfer_err),
        .ev_host_err   (ev_host_err),
        .ev_proc_err   (ev_proc_err),
        .conn_evt      (conn_evt),
        .regs          (regs),
        .ctl_reset     (ctl_reset),
        .glob_pulse    (glob_rst_pulse)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic sel;
        assign sel = bus_wr && (req.size == SZ_WORD) && port_space &&
                     (bus_addr[IDX_W:1] == IDX_W'(g)) && !bus_addr[0];
        usbhc_port u_port (
            .clk       (clk),
            .rst       (rst),
            .ctl_reset (ctl_reset),
            .wr_sel    (sel),
            .wdata     (bus_wdata[15:0]),
            .attach    (dev_attach[g]),
            .detach    (dev_detach[g]),
            .lowspeed  (dev_lowspeed[g]),
            .ctrl      (port_ctrl[g]),
            .rst_pulse (port_rst_pulse[g])
        );
    end

    usbhc_irq u_irq (
        .sts (regs.sts),
        .src (regs.src),
        .ien (regs.ien),
        .irq (irq)
    );

    assign run = regs.cmd[CB_RUN];

    always_comb begin
        bus_rdata = 32'h0;
        case (req.size)
            SZ_BYTE: bus_rdata = (bus_addr == A_SOF) ? {24'h0, regs.sof} : 32'h0000_00ff;
            SZ_LONG: bus_rdata = (bus_addr == A_FLB) ? regs.flb : 32'hffff_ffff;
            SZ_WORD: begin
                bus_rdata = {16'h0, PORT_ABSENT};
                case (bus_addr)
                    A_CMD: bus_rdata = {16'h0, regs.cmd};
                    A_STS: bus_rdata = {{(32-STS_W){1'b0}}, regs.sts};
                    A_IEN: bus_rdata = {16'h0, regs.ien};
                    A_FRN: bus_rdata = {{(32-FRN_W){1'b0}}, regs.frn};
                    default: begin
                        for (int i = 0; i < NPORTS; i++)
                            if (port_space && bus_addr[IDX_W:1] == IDX_W'(i) && !bus_addr[0])
                                bus_rdata = {16'h0, port_ctrl[i]};
                    end
                endcase
            end
            default: bus_rdata = 32'h0;
        endcase
    end

    AST_FATAL_IRQ: assert property (@(posedge clk) disable iff (rst)
        ev_host_err |=> irq); // R4

endmodule

// File: tb/usbhc_regfile_bench.sv
module usbhc_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [1:0] bus_size = 2'd3;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic ev_fd = 0, ev_sp = 0, ev_xe = 0, ev_he = 0, ev_pe = 0, ev_rs = 0;
    logic [NP-1:0] att = '0, det = '0, ls = '0;
    logic irq, run, grp;
    logic [NP-1:0] prp;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbhc_regfile #(.NPORTS(NP)) u_usbhc_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_frame_done(ev_fd), .ev_short_pkt(ev_sp), .ev_xfer_err(ev_xe),
        .ev_host_err(ev_he), .ev_proc_err(ev_pe), .ev_resume(ev_rs),
        .dev_attach(att), .dev_detach(det), .dev_lowspeed(ls),
        .irq(irq), .run(run), .port_rst_pulse(prp), .glob_rst_pulse(grp)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_cmd, m_ien;
    logic [5:0]  m_sts;
    logic [1:0]  m_src;
    logic [10:0] m_frn;
    logic [31:0] m_flb;
    logic [7:0]  m_sof;
    logic [15:0] m_port [NP];
    logic [NP-1:0] e_prp;
    logic e_grp;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic f_irq();
        return (m_src[0] & m_ien[2]) | (m_src[1] & m_ien[3]) |
               (m_sts[1] & m_ien[0]) | (m_sts[2] & m_ien[1]) | m_sts[3] | m_sts[4];
    endfunction

    function automatic logic [15:0] f_pwrite(logic [15:0] o, logic [15:0] w);
        return ((o & 16'h01fb) | (w & 16'hfe04)) & ~(w & 16'h000a);
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_ien = 0; m_sts = 0; m_src = 0; m_frn = 0; m_flb = 0; m_sof = 8'd64;
        for (int i = 0; i < NP; i++)
            m_port[i] = m_port[i][0] ? (16'h0083 | (m_port[i] & 16'h0100)) : 16'h0080;
    endtask

    task automatic model_step(logic wr, logic [1:0] sz, logic [4:0] a, logic [31:0] d);
        e_prp = '0; e_grp = 0;
        if (wr && sz == 2'd1) begin
            if (a == 5'h00) begin
                if (d[1] | d[2]) begin
                    e_grp = d[2];
                    model_reset();
                end else begin
                    if (d[0] && !m_cmd[0]) m_sts[5] = 0;
                    else if (!d[0]) m_sts[5] = 1;
                    m_cmd = d[15:0];
                end
            end else if (a == 5'h02) begin
                m_sts = m_sts & ~d[5:0];
                if (d[0]) m_src = 0;
            end else if (a == 5'h04) m_ien = d[15:0];
            else if (a == 5'h06) begin
                if (m_sts[5]) m_frn = d[10:0];
            end else begin
                for (int i = 0; i < NP; i++)
                    if (a == 5'(16 + 2*i)) begin
                        if (d[9] && !m_port[i][9]) e_prp[i] = 1;
                        m_port[i] = f_pwrite(m_port[i], d[15:0]);
                    end
            end
        end else if (wr && sz == 2'd2 && a == 5'h08) m_flb = d & 32'hffff_f000;
        else if (wr && sz == 2'd0 && a == 5'h0c) m_sof = d[7:0];
        for (int i = 0; i < NP; i++) begin
            if (att[i]) m_port[i] = (m_port[i] | 16'h0003) & ~16'h0100 | (ls[i] ? 16'h0100 : 16'h0);
            else if (det[i]) begin
                if (m_port[i][0]) begin m_port[i][0] = 0; m_port[i][1] = 1; end
                if (m_port[i][2]) begin m_port[i][2] = 0; m_port[i][3] = 1; end
            end
        end
        if (ev_fd) begin m_src[0] = 1; m_sts[0] = 1; end
        if (ev_sp) begin m_src[1] = 1; m_sts[0] = 1; end
        if (ev_xe) m_sts[1] = 1;
        if (ev_he) m_sts[3] = 1;
        if (ev_pe) m_sts[4] = 1;
        if (((|att) || (|det) || ev_rs) && m_cmd[3]) begin m_cmd[4] = 1; m_sts[2] = 1; end
    endtask

    task automatic rd(string tag, logic [1:0] sz, logic [4:0] a, logic [31:0] exp);
        bus_wr = 0; bus_size = sz; bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_all(string ctx);
        chk({ctx, "/R4 irq"}, {31'h0, irq}, {31'h0, f_irq()});
        chk({ctx, "/R1 run"}, {31'h0, run}, {31'h0, m_cmd[0]});
        chk({ctx, "/R7 pulse"}, {30'h0, prp}, {30'h0, e_prp});
        chk({ctx, "/R1 glob pulse"}, {31'h0, grp}, {31'h0, e_grp});
        rd({ctx, "/R1 cmd"}, 2'd1, 5'h00, {16'h0, m_cmd});
        rd({ctx, "/R2 sts"}, 2'd1, 5'h02, {26'h0, m_sts});
        rd({ctx, "/R4 ien"}, 2'd1, 5'h04, {16'h0, m_ien});
        rd({ctx, "/R5 frn"}, 2'd1, 5'h06, {21'h0, m_frn});
        rd({ctx, "/R5 flb"}, 2'd2, 5'h08, m_flb);
        rd({ctx, "/R5 sof"}, 2'd0, 5'h0c, {24'h0, m_sof});
        rd({ctx, "/R6 port0"}, 2'd1, 5'h10, {16'h0, m_port[0]});
        rd({ctx, "/R6 port1"}, 2'd1, 5'h12, {16'h0, m_port[1]});
        rd({ctx, "/R10 absent port"}, 2'd1, 5'h14, 32'h0000_ff7f);
    endtask

    // one clocked operation: write and/or events
    task automatic step(string ctx, logic wr, logic [1:0] sz, logic [4:0] a, logic [31:0] d,
                        logic [NP-1:0] at, logic [NP-1:0] dt, logic [NP-1:0] l,
                        logic [5:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        att = at; det = dt; ls = l;
        {ev_rs, ev_pe, ev_he, ev_xe, ev_sp, ev_fd} = ev;
        @(posedge clk);
        #1;
        model_step(wr, sz, a, d);
        bus_wr = 0; att = 0; det = 0; ls = 0;
        {ev_rs, ev_pe, ev_he, ev_xe, ev_sp, ev_fd} = '0;
        check_all(ctx);
    endtask

    task automatic wrw(string ctx, logic [4:0] a, logic [15:0] d);
        step(ctx, 1, 2'd1, a, {16'h0, d}, '0, '0, '0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NP; i++) m_port[i] = 16'h0080;
        model_reset();
        e_prp = '0; e_grp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        check_all("reset");

        // R10 unmapped reads and mismatched writes
        rd("R10 byte other", 2'd0, 5'h00, 32'h0000_00ff);
        rd("R10 long other", 2'd2, 5'h04, 32'hffff_ffff);
        rd("R10 word unmapped", 2'd1, 5'h0a, 32'h0000_ff7f);
        rd("R10 none", 2'd3, 5'h00, 32'h0);
        step("R10 wrong size", 1, 2'd2, 5'h04, 32'h0000_000f, '0, '0, '0, '0);
        step("R10 absent port", 1, 2'd1, 5'h14, 32'h0000_0204, '0, '0, '0, '0);

        // R3 halt / run
        wrw("R3 stop", 5'h00, 16'h0000);
        wrw("R5 frn halted", 5'h06, 16'hffff);
        wrw("R3 start", 5'h00, 16'h0001);
        wrw("R3 run again", 5'h00, 16'h0001);
        wrw("R5 frn locked", 5'h06, 16'h0123);
        step("R5 base", 1, 2'd2, 5'h08, 32'hdead_beef, '0, '0, '0, '0);

        // R4 interrupt sources
        wrw("R4 enables", 5'h04, 16'h0004);
        step("R4 frame done", 0, 2'd3, 0, 0, '0, '0, '0, 6'b000001);
        step("R4 short masked", 0, 2'd3, 0, 0, '0, '0, '0, 6'b000010);
        wrw("R2 clear int", 5'h02, 16'h0001);
        step("R4 host err", 0, 2'd3, 0, 0, '0, '0, '0, 6'b000100 << 1);
        // R12 event beats clearing write
        step("R12 event over write", 1, 2'd1, 5'h02, 32'h0000_003f, '0, '0, '0, 6'b001100);

        // R8 attach/detach, R6 masking, R7 pulse
        step("R8 attach ls", 0, 2'd3, 0, 0, 2'b01, '0, 2'b01, '0);
        wrw("R6 enable", 5'h10, 16'h0006);
        wrw("R7 port reset", 5'h10, 16'h0204);
        wrw("R7 hold reset", 5'h10, 16'h0204);
        step("R8 detach", 0, 2'd3, 0, 0, '0, 2'b01, '0, '0);
        wrw("R6 ack changes", 5'h10, 16'h000a);
        step("R8 attach fs p1", 0, 2'd3, 0, 0, 2'b10, '0, '0, '0);

        // R9 resume with suspend enable
        wrw("R9 suspend en", 5'h00, 16'h0009);
        step("R9 resume", 0, 2'd3, 0, 0, '0, '0, '0, 6'b100000);
        step("R9 detach", 0, 2'd3, 0, 0, '0, 2'b01, '0, '0);

        // R11 reset keeps connected ports, R1 global reset pulse
        step("R11 attach ls p0", 0, 2'd3, 0, 0, 2'b01, '0, 2'b01, '0);
        wrw("R1 R11 global reset", 5'h00, 16'h0004);
        wrw("R11 ctl reset", 5'h00, 16'h0002);

        // random traffic
        for (int k = 0; k < 600; k++) begin
            logic [4:0] a;
            logic [1:0] sz;
            logic [31:0] d;
            logic wr;
            logic [5:0] ev;
            logic [NP-1:0] at, dt;
            int r;
            r  = $urandom % 10;
            d  = $urandom;
            wr = ($urandom % 4) != 0;
            sz = 2'd1;
            case (r)
                0: begin a = 5'h00; if ($urandom % 8 != 0) d[2:1] = 2'b00; end
                1: a = 5'h02;
                2: a = 5'h04;
                3: a = 5'h06;
                4: begin a = 5'h08; sz = ($urandom % 4 == 0) ? 2'd1 : 2'd2; end
                5: begin a = 5'h0c; sz = ($urandom % 4 == 0) ? 2'd1 : 2'd0; end
                6: a = 5'h10;
                7: a = 5'h12;
                8: a = 5'h14;
                default: a = 5'h00;
            endcase
            if (r == 9) d[2:1] = 2'b00;
            ev = 6'($urandom) & 6'($urandom) & 6'($urandom);
            at = NP'($urandom) & NP'($urandom);
            dt = NP'($urandom) & NP'($urandom);
            step("rand R6 R8 R12", wr, sz, a, d, at, dt, NP'($urandom), ev);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule